// File: doc/BRIEF.md
# Deferred Parity Error Tracker

This block sits beside a parity-protected instruction queue and a register file. It decides whether a parity fault is real. When an instruction leaves the queue for execution, the block checks the stored word against its parity bit. A failed check does not raise an alarm. Instead the block marks the queue entry as suspect. The alarm is raised only when suspect state is about to be consumed, so faults in work that is later thrown away cause no error.

Two policies are selected by a configuration input. In commit policy, a suspect entry raises an error when it retires on the correct path. In propagate policy, the suspect mark moves with the result into the destination register. The error is raised only when that register is read. A result that is overwritten or never read therefore causes no error. Entries flagged as harmless at issue, and entries that are squashed or retire on a wrong path, never raise an error.

Each error is reported as a one-cycle pulse. The pulse carries a source flag and the index of the queue entry or the number of the register that caused it.

Top module: `pib_tracker`

## Requirements
- R1: At issue, the entry is suspect when the XOR of the stored word and its parity bit is 1 (even parity). A suspect entry is marked only. Issue alone never causes a pulse in the following cycle.
- R2: If the harmless flag (`iss_neutral`) is set at issue, the entry is left unmarked, whatever its parity.
- R3: In commit policy (`mode_prop`=0), retiring a marked entry on the correct path gives `err_pulse`=1 in the next cycle, with `err_from_reg`=0 and `err_id`=the queue index. Retiring an unmarked entry gives no pulse. In this policy, commits leave the register marks unchanged.
- R4: A retirement with `cmt_wrong_path`=1 never causes a pulse, and it frees the entry's mark.
- R5: A squash clears the mark of its entry. A later retirement of that index with no new issue gives no pulse.
- R6: In propagate policy (`mode_prop`=1), a correct-path retirement with a destination (`cmt_has_dst`=1) copies the entry's mark into register `cmt_dst` and causes no pulse.
- R7: Reading a marked register gives `err_pulse`=1 in the next cycle, with `err_from_reg`=1 and `err_id`=the register number. Every such read repeats the pulse.
- R8: A correct-path retirement in propagate policy that writes an unmarked result clears the register's mark. A marked register that is overwritten before it is read never causes a pulse.
- R9: In propagate policy, a marked correct-path retirement with no destination gives a queue-sourced pulse, as in R3.
- R10: If a register-read error and a commit error occur in the same cycle, only the register-read error is reported.
- R11: After reset, all marks are clear, `err_pulse`=0 and `err_id`=0. `err_id` is also 0 in every cycle without a pulse.
- R12: A read and a write to the same register in the same cycle return the mark held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_prop | input | 1 | 0 = commit policy, 1 = propagate policy |
| iss_valid | input | 1 | Entry issued this cycle |
| iss_idx | input | log2(QDEPTH) | Issued queue index |
| iss_word | input | WORD_W | Stored instruction word |
| iss_par | input | 1 | Stored parity bit |
| iss_neutral | input | 1 | Harmless instruction (anti-mark) |
| cmt_valid | input | 1 | Entry retires this cycle |
| cmt_idx | input | log2(QDEPTH) | Retiring queue index |
| cmt_wrong_path | input | 1 | Retirement is on a wrong path |
| cmt_has_dst | input | 1 | Retiring entry writes a register |
| cmt_dst | input | log2(NREG) | Destination register |
| sq_valid | input | 1 | Entry squashed this cycle |
| sq_idx | input | log2(QDEPTH) | Squashed queue index |
| rd_valid | input | 1 | Register read this cycle |
| rd_reg | input | log2(NREG) | Register being read |
| err_pulse | output | 1 | One-cycle error pulse |
| err_from_reg | output | 1 | 1 = register source, 0 = queue source |
| err_id | output | max of index widths | Responsible queue index or register number |

## Verification
The hardest situation to reach is a collision of two events. One case is a marked register being read in the same cycle as it is overwritten. Another is a register read that coincides with a marked retirement, which tests which error wins. Random traffic rarely lines up both in one cycle, so directed steps first set up a marked register and then drive both events together. After that, seeded random traffic with frequent parity faults and policy switches runs against a bench model of both mark arrays.

// File: rtl/pib_pkg.sv
package pib_pkg;
  typedef enum logic {
    SRC_QUEUE = 1'b0,
    SRC_REG   = 1'b1
  } err_src_e;

  typedef enum logic {
    POL_COMMIT    = 1'b0,
    POL_PROPAGATE = 1'b1
  } policy_e;

  // Pick the reported index: a register read outranks a retirement.
  function automatic logic [15:0] pick_id(input logic rd_hit, input logic [15:0] reg_no,
                                          input logic cm_hit, input logic [15:0] q_idx);
    if (rd_hit) return reg_no;
    if (cm_hit) return q_idx;
    return 16'd0;
  endfunction
endpackage

// File: rtl/pib_qtags.sv
module pib_qtags #(
  parameter int QDEPTH = 8,
  parameter int WORD_W = 16,
  localparam int QIW = $clog2(QDEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_prop,
  input  logic              iss_valid,
  input  logic [QIW-1:0]    iss_idx,
  input  logic [WORD_W-1:0] iss_word,
  input  logic              iss_par,
  input  logic              iss_neutral,
  input  logic              cmt_valid,
  input  logic [QIW-1:0]    cmt_idx,
  input  logic              cmt_wrong_path,
  input  logic              cmt_has_dst,
  input  logic              sq_valid,
  input  logic [QIW-1:0]    sq_idx,
  output logic              cmt_err_evt,
  output logic              fwd_wr,
  output logic              fwd_tag
);
  import pib_pkg::*;

  function automatic logic parity_bad(input logic [WORD_W-1:0] w, input logic p);
    return ^{w, p};
  endfunction

  logic [QDEPTH-1:0] tags;
  logic              new_tag;
  logic              cmt_tag;
  logic              cmt_good;

  assign new_tag  = parity_bad(iss_word, iss_par) & ~iss_neutral;
  assign cmt_tag  = tags[cmt_idx];
  assign cmt_good = cmt_valid & ~cmt_wrong_path;

  assign fwd_wr      = cmt_good & cmt_has_dst & (mode_prop == POL_PROPAGATE);
  assign fwd_tag     = cmt_tag;
  assign cmt_err_evt = cmt_good & cmt_tag & ~fwd_wr;

  for (genvar g = 0; g < QDEPTH; g++) begin : g_entry
    logic hit_iss, hit_free;
    assign hit_iss  = iss_valid & (iss_idx == QIW'(g));
    assign hit_free = (cmt_valid & (cmt_idx == QIW'(g))) | (sq_valid & (sq_idx == QIW'(g)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        tags[g] <= 1'b0;
      else if (hit_iss)  tags[g] <= new_tag;
      else if (hit_free) tags[g] <= 1'b0;
    end
  end

  p_neutral_unmarked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && iss_neutral |=> !tags[$past(iss_idx)]);

  p_squash_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sq_valid && !(iss_valid && iss_idx == sq_idx) |=> !tags[$past(sq_idx)]);

  p_wrong_path_frees_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_valid && cmt_wrong_path && !(iss_valid && iss_idx == cmt_idx) |=> !tags[$past(cmt_idx)]);
endmodule

// File: rtl/pib_rtags.sv
module pib_rtags #(
  parameter int NREG = 16,
  localparam int RIW = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [RIW-1:0] wr_reg,
  input  logic           wr_tag,
  input  logic           rd_valid,
  input  logic [RIW-1:0] rd_reg,
  output logic           rd_err_evt
);
  logic [NREG-1:0] rtag;

  // Read sees the mark held before any same-cycle write.
  assign rd_err_evt = rd_valid & rtag[rd_reg];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              rtag[g] <= 1'b0;
      else if (wr_en && wr_reg == RIW'(g))     rtag[g] <= wr_tag;
    end
  end

  p_clean_write_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_tag |=> !rtag[$past(wr_reg)]);

  p_marked_write_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_tag |=> rtag[$past(wr_reg)]);
endmodule

// File: rtl/pib_report.sv
module pib_report #(
  parameter int QIW = 3,
  parameter int RIW = 4,
  localparam int IDW = (QIW > RIW) ? QIW : RIW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmt_err_evt,
  input  logic [QIW-1:0] cmt_idx,
  input  logic           rd_err_evt,
  input  logic [RIW-1:0] rd_reg,
  output logic           err_pulse,
  output logic           err_from_reg,
  output logic [IDW-1:0] err_id
);
  import pib_pkg::*;

  logic [15:0] id_next;
  assign id_next = pick_id(rd_err_evt, 16'(rd_reg), cmt_err_evt, 16'(cmt_idx));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_pulse    <= 1'b0;
      err_from_reg <= SRC_QUEUE;
      err_id       <= '0;
    end else begin
      err_pulse    <= rd_err_evt | cmt_err_evt;
      err_from_reg <= rd_err_evt ? SRC_REG : SRC_QUEUE;
      err_id       <= id_next[IDW-1:0];
    end
  end

  p_read_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err_evt |=> err_pulse && err_from_reg && err_id == IDW'($past(rd_reg)));

  p_commit_report_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_err_evt && !rd_err_evt |=> err_pulse && !err_from_reg && err_id == IDW'($past(cmt_idx)));
endmodule

// File: rtl/pib_tracker.sv
module pib_tracker #(
  parameter int QDEPTH = 8,
  parameter int WORD_W = 16,
  parameter int NREG   = 16,
  localparam int QIW = $clog2(QDEPTH),
  localparam int RIW = $clog2(NREG),
  localparam int IDW = (QIW > RIW) ? QIW : RIW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_prop,
  input  logic              iss_valid,
  input  logic [QIW-1:0]    iss_idx,
  input  logic [WORD_W-1:0] iss_word,
  input  logic              iss_par,
  input  logic              iss_neutral,
  input  logic              cmt_valid,
  input  logic [QIW-1:0]    cmt_idx,
  input  logic              cmt_wrong_path,
  input  logic              cmt_has_dst,
  input  logic [RIW-1:0]    cmt_dst,
  input  logic              sq_valid,
  input  logic [QIW-1:0]    sq_idx,
  input  logic              rd_valid,
  input  logic [RIW-1:0]    rd_reg,
  output logic              err_pulse,
  output logic              err_from_reg,
  output logic [IDW-1:0]    err_id
);
  logic cmt_err_evt, fwd_wr, fwd_tag, rd_err_evt;

  pib_qtags #(.QDEPTH(QDEPTH), .WORD_W(WORD_W)) u_q (
    .clk, .rst_n, .mode_prop,
    .iss_valid, .iss_idx, .iss_word, .iss_par, .iss_neutral,
    .cmt_valid, .cmt_idx, .cmt_wrong_path, .cmt_has_dst,
    .sq_valid, .sq_idx,
    .cmt_err_evt, .fwd_wr, .fwd_tag
  );

  pib_rtags #(.NREG(NREG)) u_r (
    .clk, .rst_n,
    .wr_en(fwd_wr), .wr_reg(cmt_dst), .wr_tag(fwd_tag),
    .rd_valid, .rd_reg, .rd_err_evt
  );

  pib_report #(.QIW(QIW), .RIW(RIW)) u_rep (
    .clk, .rst_n, .cmt_err_evt, .cmt_idx, .rd_err_evt, .rd_reg,
    .err_pulse, .err_from_reg, .err_id
  );

  p_quiet_without_consumer_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cmt_valid && !rd_valid |=> !err_pulse);

  p_wrong_path_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_valid && cmt_wrong_path && !rd_valid |=> !err_pulse);

  p_idle_id_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !err_pulse |-> err_id == '0);
endmodule

// File: tb/sim_pib_tracker.sv
module sim_pib_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int QDEPTH = 8, WORD_W = 16, NREG = 16;
  localparam int QIW = $clog2(QDEPTH), RIW = $clog2(NREG);
  localparam int IDW = (QIW > RIW) ? QIW : RIW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_prop, iss_valid, iss_par, iss_neutral, cmt_valid, cmt_wrong_path, cmt_has_dst;
  logic sq_valid, rd_valid;
  logic [QIW-1:0] iss_idx, cmt_idx, sq_idx;
  logic [RIW-1:0] cmt_dst, rd_reg;
  logic [WORD_W-1:0] iss_word;
  logic err_pulse, err_from_reg;
  logic [IDW-1:0] err_id;

  int total = 0, bad = 0;
  bit m_q[QDEPTH];
  bit m_r[NREG];

  always #(CLK_PERIOD/2) clk = ~clk;

  pib_tracker #(.QDEPTH(QDEPTH), .WORD_W(WORD_W), .NREG(NREG)) u0 (.*);

  function automatic bit word_bad(input logic [WORD_W-1:0] w, input logic p);
    int ones = 0;
    for (int i = 0; i < WORD_W; i++) ones += w[i];
    return ((ones + p) % 2) == 1;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_in();
    iss_valid = 0; iss_idx = '0; iss_word = '0; iss_par = 0; iss_neutral = 0;
    cmt_valid = 0; cmt_idx = '0; cmt_wrong_path = 0; cmt_has_dst = 0; cmt_dst = '0;
    sq_valid = 0; sq_idx = '0; rd_valid = 0; rd_reg = '0;
  endtask

  // One cycle: predict, clock, compare, update model.
  task automatic step(input string req);
    bit rd_e, cm_e, fwd, oldtag;
    logic [IDW-1:0] eid;
    oldtag = m_q[cmt_idx];
    fwd  = cmt_valid && !cmt_wrong_path && cmt_has_dst && mode_prop;
    rd_e = rd_valid && m_r[rd_reg];
    cm_e = cmt_valid && !cmt_wrong_path && oldtag && !fwd;
    eid  = rd_e ? IDW'(rd_reg) : (cm_e ? IDW'(cmt_idx) : '0);
    @(posedge clk); #1;
    check({req, " pulse"}, 32'(err_pulse), 32'(rd_e | cm_e));
    check({req, " src"}, 32'(err_from_reg), 32'(rd_e));
    check({req, " id"}, 32'(err_id), 32'(eid));
    if (cmt_valid) m_q[cmt_idx] = 0;
    if (sq_valid) m_q[sq_idx] = 0;
    if (iss_valid) m_q[iss_idx] = word_bad(iss_word, iss_par) && !iss_neutral;
    if (fwd) m_r[cmt_dst] = oldtag;
    @(negedge clk);
    idle_in();
  endtask

  task automatic issue(input int idx, input bit faulty, input bit neutral);
    iss_valid = 1; iss_idx = QIW'(idx); iss_word = 16'h5a3c ^ 16'(idx);
    iss_par = (^iss_word) ^ faulty; iss_neutral = neutral;
  endtask

  task automatic retire(input int idx, input bit wp, input bit dst, input int r);
    cmt_valid = 1; cmt_idx = QIW'(idx); cmt_wrong_path = wp; cmt_has_dst = dst; cmt_dst = RIW'(r);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    seed = 11;
    void'($urandom(seed));
    idle_in(); mode_prop = 0;
    repeat (3) @(negedge clk);
    check("R11 reset pulse", 32'(err_pulse), 0);
    check("R11 reset id", 32'(err_id), 0);
    rst_n = 1;
    @(negedge clk);

    // Commit policy
    issue(2, 1, 0); step("R1 issue faulty");
    retire(2, 0, 0, 0); step("R3 commit marked");
    issue(1, 0, 0); step("R1 issue clean");
    retire(1, 0, 0, 0); step("R1 commit clean");
    issue(3, 1, 1); step("R2 neutral issue");
    retire(3, 0, 0, 0); step("R2 neutral commit");
    issue(4, 1, 0); step("R4 issue");
    retire(4, 0, 0, 0); cmt_wrong_path = 1; step("R4 wrong path commit");
    issue(5, 1, 0); step("R5 issue");
    sq_valid = 1; sq_idx = 3'd5; step("R5 squash");
    retire(5, 0, 0, 0); step("R5 commit after squash");

    // Propagate policy
    mode_prop = 1;
    issue(6, 1, 0); step("R6 issue");
    retire(6, 0, 1, 9); step("R6 commit to reg");
    rd_valid = 1; rd_reg = 4'd9; step("R7 read marked");
    rd_valid = 1; rd_reg = 4'd9; step("R7 read again");
    issue(7, 0, 0); step("R8 clean issue");
    retire(7, 0, 1, 9); step("R8 clean overwrite");
    rd_valid = 1; rd_reg = 4'd9; step("R8 read after overwrite");
    issue(0, 1, 0); step("R8 dead issue");
    retire(0, 0, 1, 3); step("R8 dead commit");
    issue(0, 0, 0); step("R8 kill issue");
    retire(0, 0, 1, 3); step("R8 kill commit");
    rd_valid = 1; rd_reg = 4'd3; step("R8 dead never reported");
    issue(1, 1, 0); step("R9 issue");
    retire(1, 0, 0, 0); step("R9 commit no dst");
    issue(2, 1, 0); step("R10 setup");
    retire(2, 0, 1, 4); step("R10 mark reg4");
    issue(2, 1, 0); step("R10 setup2");
    retire(2, 0, 0, 0); rd_valid = 1; rd_reg = 4'd4; step("R10 read wins");
    issue(3, 0, 0); step("R12 setup");
    retire(3, 0, 1, 4); rd_valid = 1; rd_reg = 4'd4; step("R12 read old mark");
    rd_valid = 1; rd_reg = 4'd4; step("R12 read after write");
    issue(5, 1, 0); step("R3 mark reg5 setup");
    retire(5, 0, 1, 5); step("R3 mark reg5");
    mode_prop = 0;
    issue(6, 0, 0); step("R3 clean issue");
    retire(6, 0, 1, 5); step("R3 commit leaves reg");
    rd_valid = 1; rd_reg = 4'd5; step("R3 reg mark kept");

    // Random traffic
    for (int c = 0; c < 4000; c++) begin
      int a, b, s;
      if (c % 300 == 0) mode_prop = $urandom_range(0, 1);
      a = $urandom_range(0, QDEPTH-1);
      b = (a + $urandom_range(1, QDEPTH-1)) % QDEPTH;
      s = (b + 1) % QDEPTH;
      if (s == a) s = (s + 1) % QDEPTH;
      if ($urandom_range(0, 1)) begin
        iss_valid = 1; iss_idx = QIW'(a); iss_word = 16'($urandom);
        iss_par = (^iss_word) ^ ($urandom_range(0, 9) < 4);
        iss_neutral = ($urandom_range(0, 9) < 2);
      end
      if ($urandom_range(0, 1))
        retire(b, $urandom_range(0, 9) < 2, $urandom_range(0, 9) < 7, $urandom_range(0, NREG-1));
      if ($urandom_range(0, 9) < 2) begin sq_valid = 1; sq_idx = QIW'(s); end
      if ($urandom_range(0, 1)) begin rd_valid = 1; rd_reg = RIW'($urandom_range(0, NREG-1)); end
      step("R7 R9 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule